// File: doc/BRIEF.md
# DDR Channel Command Issue Scheduler

This block picks, on every clock, at most one command for a single DDR channel. It chooses from two small internal queues: a read request queue and a posted-write buffer. Each queue entry carries the ID of the device it targets. The chosen command is signalled by an issue strobe, a read/write type bit and the target device ID. In the same cycle, the chosen entry is removed from its queue.

Reads always come first. A write is considered only while the read queue is empty. Two reads are separated by a programmable number of idle cycles. A mode bit lets reads to the device used by the previous read issue back to back, so the spacing then applies only when the device changes. A second mode bit holds writes back until four are posted. Once that threshold is met, the writes stream out until a read arrives. After the read, the threshold applies again. While this mode is set, up to three writes can wait in the buffer for any length of time.

The three settings are captured into a configuration register by a load strobe. The register resets to all zeros, which selects strict read spacing, zero gap and immediate write drain.

Top module: `ddr_cmd_sched`

## Requirements
- R1: After reset, `issue_o`, `rd_full_o` and `wr_full_o` are low, and the configuration register holds opt=0, batch=0, gap=0. One posted write therefore issues with no configuration load.
- R2: No write issues in a cycle where the read queue holds an entry, even when that read is blocked by spacing. When both kinds are pending, the read issues.
- R3: With batch=0 and no read pending, a write accepted at a clock edge issues (`issue_o`=1, `issue_is_wr_o`=1) in the cycle that follows that edge. Later writes issue one per cycle.
- R4: With batch=1, no write issues while one to three writes are buffered and no burst is active. When the fourth write is accepted, the buffered writes issue on consecutive cycles.
- R5: A read that arrives during a write burst issues in the next cycle and ends the burst. After the read, the remaining writes wait again until four are buffered.
- R6: With opt=0 and a programmed gap G (4 bits), two reads issued in cycles a and b satisfy b-a >= G+1. When reads are queued, b-a = G+1 exactly.
- R7: With opt=1, a read to the same device as the previous read issues in the next cycle. A read to a different device still waits G+1 cycles after the previous read.
- R8: Each queue holds 8 entries. Its full flag is high while 8 entries are held. A push into a full queue is dropped.
- R9: At most one command issues per cycle. Within each queue, commands issue in arrival order, and each entry issues exactly once.
- R10: The configuration register changes only in a cycle where `cfg_we_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load strobe for the configuration register |
| cfg_rr_opt_i | input | 1 | Allow back-to-back reads to the same device |
| cfg_wr_batch_i | input | 1 | Hold writes until four are posted |
| cfg_rr_gap_i | input | 4 | Minimum idle cycles between reads |
| rd_valid_i | input | 1 | Read request push |
| rd_dev_i | input | DEV_W | Device ID of the pushed read |
| rd_full_o | output | 1 | Read queue full |
| wr_valid_i | input | 1 | Posted write push |
| wr_dev_i | input | DEV_W | Device ID of the pushed write |
| wr_full_o | output | 1 | Write buffer full |
| issue_o | output | 1 | A command issues this cycle |
| issue_is_wr_o | output | 1 | 1 = write, 0 = read |
| issue_dev_o | output | DEV_W | Device ID of the issued command |

## Verification
The hardest states to reach are a read arriving in the middle of a write burst, and a full read queue with writes piling up behind it. For the first, the bench posts four writes under batch mode and pushes a read at the very edge where the first write leaves. It then checks that three writes remain stranded until one more write is posted. For the second, a 15-cycle read gap stalls the read queue. This lets the bench fill both queues past capacity. It then checks that dropped entries never appear and that every write waits for the last read.

// File: rtl/ddr_sched_pkg.sv
package ddr_sched_pkg;
  localparam int unsigned GAP_W = 4;

  typedef struct packed {
    logic             rr_opt;
    logic             wr_batch;
    logic [GAP_W-1:0] rr_gap;
  } sched_cfg_t;
endpackage

// File: rtl/sched_fifo.sv
module sched_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 4,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             push_ok, pop_ok;

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign count_o = count_q;
  assign data_o  = mem_q[rd_ptr_q];
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= data_i;
  end

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));

  p_full_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> $stable(count_q));
endmodule

// File: rtl/rd_spacer.sv
module rd_spacer #(
  parameter int unsigned GAP_W = 4,
  parameter int unsigned DEV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [GAP_W-1:0] gap_i,
  input  logic             opt_i,
  input  logic [DEV_W-1:0] head_dev_i,
  input  logic             rd_issue_i,
  output logic             rd_ok_o
);
  logic [GAP_W-1:0] cnt_q;
  logic [DEV_W-1:0] last_dev_q;

  // cnt_q != 0 implies a read was issued, so last_dev_q is meaningful
  assign rd_ok_o = (cnt_q == '0) || (opt_i && (head_dev_i == last_dev_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      last_dev_q <= '0;
    end else if (rd_issue_i) begin
      cnt_q      <= gap_i;
      last_dev_q <= head_dev_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  p_gap_strict_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_issue_i && !opt_i) |-> (cnt_q == '0));

  p_gap_same_dev_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_issue_i && (cnt_q != '0)) |-> (head_dev_i == last_dev_q));
endmodule

// File: rtl/wr_gate.sv
module wr_gate #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned BATCH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             batch_i,
  input  logic [CNT_W-1:0] wr_count_i,
  input  logic             rd_pending_i,
  input  logic             wr_issue_i,
  output logic             wr_ok_o
);
  logic burst_q;
  logic thresh_met;

  assign thresh_met = (wr_count_i >= CNT_W'(BATCH));
  assign wr_ok_o    = !rd_pending_i && (wr_count_i != '0) &&
                      (!batch_i || burst_q || thresh_met);

  // burst continues only while writes issue back to back
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) burst_q <= 1'b0;
    else         burst_q <= wr_issue_i;
  end

  p_preempt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pending_i |=> !burst_q);
endmodule

// File: rtl/ddr_cmd_sched.sv
module ddr_cmd_sched
  import ddr_sched_pkg::*;
#(
  parameter int unsigned DEV_W    = 4,
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned WR_BATCH = 4,
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             cfg_rr_opt_i,
  input  logic             cfg_wr_batch_i,
  input  logic [GAP_W-1:0] cfg_rr_gap_i,
  input  logic             rd_valid_i,
  input  logic [DEV_W-1:0] rd_dev_i,
  output logic             rd_full_o,
  input  logic             wr_valid_i,
  input  logic [DEV_W-1:0] wr_dev_i,
  output logic             wr_full_o,
  output logic             issue_o,
  output logic             issue_is_wr_o,
  output logic [DEV_W-1:0] issue_dev_o
);
  sched_cfg_t       cfg_q;
  logic [DEV_W-1:0] rd_head, wr_head;
  logic             rd_empty, wr_empty;
  logic [CNT_W-1:0] rd_cnt, wr_cnt;
  logic             rd_ok, wr_ok;
  logic             issue_rd, issue_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= '{rr_opt: cfg_rr_opt_i, wr_batch: cfg_wr_batch_i,
                                  rr_gap: cfg_rr_gap_i};
  end

  sched_fifo #(.DEPTH(DEPTH), .W(DEV_W)) u_rd_q (
    .clk_i, .rst_ni,
    .push_i(rd_valid_i), .data_i(rd_dev_i), .pop_i(issue_rd),
    .data_o(rd_head), .empty_o(rd_empty), .full_o(rd_full_o), .count_o(rd_cnt)
  );

  sched_fifo #(.DEPTH(DEPTH), .W(DEV_W)) u_wr_q (
    .clk_i, .rst_ni,
    .push_i(wr_valid_i), .data_i(wr_dev_i), .pop_i(issue_wr),
    .data_o(wr_head), .empty_o(wr_empty), .full_o(wr_full_o), .count_o(wr_cnt)
  );

  rd_spacer #(.GAP_W(GAP_W), .DEV_W(DEV_W)) u_spacer (
    .clk_i, .rst_ni,
    .gap_i(cfg_q.rr_gap), .opt_i(cfg_q.rr_opt),
    .head_dev_i(rd_head), .rd_issue_i(issue_rd), .rd_ok_o(rd_ok)
  );

  wr_gate #(.CNT_W(CNT_W), .BATCH(WR_BATCH)) u_wr_gate (
    .clk_i, .rst_ni,
    .batch_i(cfg_q.wr_batch), .wr_count_i(wr_cnt),
    .rd_pending_i(!rd_empty), .wr_issue_i(issue_wr), .wr_ok_o(wr_ok)
  );

  assign issue_rd      = !rd_empty && rd_ok;
  assign issue_wr      = !issue_rd && wr_ok;
  assign issue_o       = issue_rd || issue_wr;
  assign issue_is_wr_o = issue_wr;
  assign issue_dev_o   = issue_wr ? wr_head : rd_head;

  p_read_priority_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o && issue_is_wr_o) |-> rd_empty);

  p_one_cmd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> (issue_is_wr_o ? !wr_empty : !rd_empty));

  p_batch_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.wr_batch && !cfg_we_i && !issue_wr)
      |=> (!issue_wr || (wr_cnt >= CNT_W'(WR_BATCH))));

  p_cfg_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(cfg_q));
endmodule

// File: tb/tb_ddr_cmd_sched.sv
module tb_ddr_cmd_sched;
  localparam int DEV_W = 4;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cfg_we_i = 1'b0, cfg_rr_opt_i = 1'b0, cfg_wr_batch_i = 1'b0;
  logic [3:0]       cfg_rr_gap_i = '0;
  logic             rd_valid_i = 1'b0, wr_valid_i = 1'b0;
  logic [DEV_W-1:0] rd_dev_i = '0, wr_dev_i = '0;
  logic             rd_full_o, wr_full_o, issue_o, issue_is_wr_o;
  logic [DEV_W-1:0] issue_dev_o;

  ddr_cmd_sched #(.DEV_W(DEV_W)) dut (.*);

  always #5 clk_i = ~clk_i;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  int cyc = 0;
  int lg_n = 0;
  int lg_cyc [64];
  int lg_wr  [64];
  int lg_dev [64];

  always @(negedge clk_i) begin
    cyc <= cyc + 1;
    if (rst_ni && issue_o && lg_n < 64) begin
      lg_cyc[lg_n] = cyc;
      lg_wr[lg_n]  = int'(issue_is_wr_o);
      lg_dev[lg_n] = int'(issue_dev_o);
      lg_n = lg_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic push_rd(input int dev);
    rd_valid_i = 1'b1; rd_dev_i = DEV_W'(dev);
    tick();
    rd_valid_i = 1'b0;
  endtask

  task automatic push_wr(input int dev);
    wr_valid_i = 1'b1; wr_dev_i = DEV_W'(dev);
    tick();
    wr_valid_i = 1'b0;
  endtask

  task automatic set_cfg(input bit opt, input bit batch, input int gap);
    cfg_rr_opt_i = opt; cfg_wr_batch_i = batch; cfg_rr_gap_i = 4'(gap);
    cfg_we_i = 1'b1;
    tick();
    cfg_we_i = 1'b0;
  endtask

  task automatic expect_entry(input int idx, input int wr, input int dev, input string req);
    chk(lg_wr[idx] == wr, req, lg_wr[idx], wr);
    chk(lg_dev[idx] == dev, req, lg_dev[idx], dev);
  endtask

  task automatic t_reset();
    chk(issue_o == 1'b0, "R1 issue after reset", int'(issue_o), 0);
    chk(rd_full_o == 1'b0 && wr_full_o == 1'b0, "R1 full flags after reset",
        int'({rd_full_o, wr_full_o}), 0);
    // R10: inputs changed without load strobe must have no effect
    cfg_rr_opt_i = 1'b1; cfg_wr_batch_i = 1'b1; cfg_rr_gap_i = 4'd5;
    lg_n = 0;
    push_wr(5);
    idle(4);
    chk(lg_n == 1, "R1 R10 single write drains in reset mode", lg_n, 1);
    expect_entry(0, 1, 5, "R1 drained write");
  endtask

  task automatic t_drain();
    set_cfg(0, 0, 0);
    lg_n = 0;
    push_wr(1); push_wr(2); push_wr(3);
    idle(5);
    chk(lg_n == 3, "R3 write count", lg_n, 3);
    for (int i = 0; i < 3; i++) expect_entry(i, 1, i + 1, "R9 write order");
    chk(lg_cyc[2] - lg_cyc[0] == 2, "R3 one write per cycle", lg_cyc[2] - lg_cyc[0], 2);
  endtask

  task automatic t_batch();
    set_cfg(0, 1, 0);
    lg_n = 0;
    push_wr(1); push_wr(2); push_wr(3);
    idle(6);
    chk(lg_n == 0, "R4 three writes held", lg_n, 0);
    push_wr(4);
    idle(6);
    chk(lg_n == 4, "R4 batch released", lg_n, 4);
    for (int i = 0; i < 4; i++) expect_entry(i, 1, i + 1, "R4 batch order");
    chk(lg_cyc[3] - lg_cyc[0] == 3, "R4 consecutive writes", lg_cyc[3] - lg_cyc[0], 3);
  endtask

  task automatic t_preempt();
    set_cfg(0, 1, 0);
    lg_n = 0;
    push_wr(1); push_wr(2); push_wr(3); push_wr(4);
    push_rd(7);
    idle(6);
    chk(lg_n == 2, "R5 burst cut by read", lg_n, 2);
    expect_entry(0, 1, 1, "R5 first write");
    expect_entry(1, 0, 7, "R5 read pre-empts");
    chk(lg_cyc[1] - lg_cyc[0] == 1, "R5 read next cycle", lg_cyc[1] - lg_cyc[0], 1);
    lg_n = 0;
    push_wr(5);
    idle(6);
    chk(lg_n == 4, "R5 threshold reapplied", lg_n, 4);
    for (int i = 0; i < 4; i++) expect_entry(i, 1, i + 2, "R5 remaining order");
  endtask

  task automatic t_spacing();
    set_cfg(0, 0, 3);
    lg_n = 0;
    push_rd(2); push_rd(2); push_rd(4); push_wr(6);
    idle(14);
    chk(lg_n == 4, "R6 command count", lg_n, 4);
    expect_entry(0, 0, 2, "R6 read 0");
    expect_entry(1, 0, 2, "R6 read 1");
    expect_entry(2, 0, 4, "R6 read 2");
    expect_entry(3, 1, 6, "R2 write after reads");
    chk(lg_cyc[1] - lg_cyc[0] == 4, "R6 same dev strict gap", lg_cyc[1] - lg_cyc[0], 4);
    chk(lg_cyc[2] - lg_cyc[1] == 4, "R6 gap", lg_cyc[2] - lg_cyc[1], 4);
    chk(lg_cyc[3] - lg_cyc[2] == 1, "R2 write waits for read queue", lg_cyc[3] - lg_cyc[2], 1);
  endtask

  task automatic t_opt();
    set_cfg(1, 0, 3);
    idle(5);
    lg_n = 0;
    push_rd(2); push_rd(2); push_rd(4); push_rd(4);
    idle(12);
    chk(lg_n == 4, "R7 read count", lg_n, 4);
    chk(lg_cyc[1] - lg_cyc[0] == 1, "R7 same dev back to back", lg_cyc[1] - lg_cyc[0], 1);
    chk(lg_cyc[2] - lg_cyc[1] == 4, "R7 dev change spaced", lg_cyc[2] - lg_cyc[1], 4);
    chk(lg_cyc[3] - lg_cyc[2] == 1, "R7 same dev again", lg_cyc[3] - lg_cyc[2], 1);
  endtask

  task automatic t_full();
    set_cfg(0, 0, 15);
    lg_n = 0;
    for (int i = 0; i < 10; i++) push_rd(i);
    chk(rd_full_o == 1'b1, "R8 read queue full", int'(rd_full_o), 1);
    for (int i = 0; i < 9; i++) push_wr(i);
    chk(wr_full_o == 1'b1, "R8 write buffer full", int'(wr_full_o), 1);
    idle(200);
    chk(lg_n == 17, "R8 dropped pushes absent", lg_n, 17);
    for (int i = 0; i < 9; i++) expect_entry(i, 0, i, "R8 R9 read order");
    for (int i = 0; i < 8; i++) expect_entry(9 + i, 1, i, "R8 R2 write order");
    chk(lg_cyc[1] - lg_cyc[0] == 16, "R6 max gap", lg_cyc[1] - lg_cyc[0], 16);
    chk(rd_full_o == 1'b0 && wr_full_o == 1'b0, "R8 full cleared",
        int'({rd_full_o, wr_full_o}), 0);
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    t_reset();
    t_drain();
    t_batch();
    idle(3);
    t_preempt();
    t_spacing();
    t_opt();
    t_full();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule